// File: doc/BRIEF.md
# USB Transmit Serializer With Raw Operating Mode

This block sits between a link layer and the line drivers of a USB transceiver. It takes bytes through a valid/ready handshake and emits one line symbol per clock, either J, K or single-ended zero (SE0). Each clock stands for one bit time. In normal operation a packet opens with a synchronisation pattern. Its bytes go out least significant bit first, with bit stuffing and NRZI coding applied. The packet closes with an end-of-packet pattern.

A 2-bit mode input selects normal or raw operation. In raw mode every data bit is mapped straight to a line state, and no framing is added. The link is expected to change the mode only while the transmitter is idle. There is one exception: switching to raw mode while a normal packet is in flight flags a transmit error. The remaining bits then go out raw, and the packet is still closed with an end-of-packet pattern once the link drops its valid signal.

Top module: `usbtx_serializer`

## Requirements
- R1: During reset and whenever no packet is in progress, `line_o` carries J (code 2'b01) and `tx_ready_o` is low. The other line codes are K = 2'b10 and SE0 = 2'b00.
- R2: In normal mode, the clock edge that first samples `tx_valid_i` high still drives J. The following eight clocks drive K J K J K J K K, one symbol per clock, before any data symbol.
- R3: In normal mode, data bits go out least significant bit first with NRZI coding: a 0 changes the line between J and K, and a 1 keeps the previous J/K state. The first data bit is coded against the final K of the synchronisation pattern.
- R4: In normal mode, after six consecutive 1 bits an extra 0 bit (a line change) is inserted before the next symbol. Runs are counted across byte boundaries, and a run that ends the last byte is stuffed before the end-of-packet pattern. The run counter starts at zero after the synchronisation pattern.
- R5: When `tx_valid_i` is low at the point where the next byte would be taken, a normal packet ends with SE0, SE0, J, and the line then stays at J.
- R6: `tx_ready_o` is high, combinationally, exactly in the cycle in which a byte is taken, and that byte is captured at the following clock edge. A byte is taken when `tx_valid_i` is high and the shifter needs a new byte, which is at the end of the synchronisation pattern, after the last bit of a byte, or on the first cycle of a raw packet. The block takes one byte per byte sent and never raises `tx_ready_o` on two clocks in a row.
- R7: When mode 2'b10 is present as the packet starts, data bits go out least significant bit first, a 1 as J and a 0 as K. No stuffing is applied and no synchronisation or end-of-packet symbols are sent. The line returns to J after the last bit.
- R8: Mode 2'b11 behaves exactly as normal mode 2'b00.
- R9: If the mode becomes 2'b10 during a normal packet, every bit sent from then on is raw (1 as J, 0 as K) and is not stuffed. When `tx_valid_i` falls, the packet still closes with SE0, SE0, J.
- R10: SE0 never lasts longer than two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid_i | input | 1 | Link has a byte to send; low ends the packet |
| tx_data_i | input | BYTE_W | Byte offered by the link |
| opmode_i | input | 2 | 00/11 normal, 10 raw, 01 treated as normal |
| tx_ready_o | output | 1 | Byte on `tx_data_i` is taken at the next edge |
| line_o | output | 2 | Line symbol: 01 J, 10 K, 00 SE0 |

## Verification
On every cycle, the checker confirms several timing properties. The ready signal is raised only while valid is high, and never on two clocks in a row. A start of valid is answered by a J. SE0 never runs past two clocks, and a pair of SE0s is followed by J. The exact symbol sequence cannot be expressed as a simple property, so the bench's scenarios show it: the synchronisation pattern, NRZI levels, stuffing at byte boundaries and before the end-of-packet pattern, the raw mapping, the reserved mode, and the raw switch in mid-packet. A behavioural model predicts that sequence and compares it with the line each clock.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10
    } sym_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_EOP
    } st_e;

    localparam logic [1:0] OPM_RAW = 2'b10;
endpackage

// File: rtl/usbtx_sym_enc.sv
// Maps one bit to a line symbol, either raw or NRZI against the previous state.
module usbtx_sym_enc
    import usbtx_pkg::*;
(
    input  logic dat_i,
    input  logic raw_i,
    input  sym_e prev_i,
    output sym_e sym_o
);
    always_comb begin
        if (raw_i) begin
            sym_o = dat_i ? SYM_J : SYM_K;
        end else if (dat_i) begin
            sym_o = prev_i;
        end else begin
            sym_o = (prev_i == SYM_K) ? SYM_J : SYM_K;
        end
    end
endmodule

// File: rtl/usbtx_sync_gen.sv
// Synchronisation symbol by index: alternating K/J, the final one doubled K.
module usbtx_sync_gen
    import usbtx_pkg::*;
#(
    parameter int SYNC_LEN = 8,
    parameter int IW       = 3
) (
    input  logic [IW-1:0] idx_i,
    output sym_e          sym_o
);
    always_comb begin
        if (idx_i == IW'(SYNC_LEN - 1)) begin
            sym_o = SYM_K;
        end else if (idx_i[0]) begin
            sym_o = SYM_J;
        end else begin
            sym_o = SYM_K;
        end
    end
endmodule

// File: rtl/usbtx_serializer.sv
module usbtx_serializer
    import usbtx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int SYNC_LEN  = 8,
    parameter int STUFF_LEN = 6,
    parameter int EOP_SE0   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic [1:0]        opmode_i,
    output logic              tx_ready_o,
    output logic [1:0]        line_o
);
    localparam int CNT_A   = (BYTE_W > SYNC_LEN) ? BYTE_W : SYNC_LEN;
    localparam int CNT_MAX = (CNT_A > EOP_SE0 + 1) ? CNT_A : EOP_SE0 + 1;
    localparam int CW      = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;
    localparam int OW      = $clog2(STUFF_LEN + 1);

    typedef struct packed {
        st_e               st;
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] sh;
        logic [OW-1:0]     ones;
        logic              raw;   // packet began in raw mode: no framing
        logic              err;   // raw entered mid-packet: error flag
        sym_e              line;
    } regs_t;

    regs_t s_q, s_d;
    logic  take;

    logic              op_raw;
    logic              raw_emit;
    logic [BYTE_W-1:0] sh_shift;
    logic              cur_bit;
    logic              stuff_due;
    sym_e              data_sym;
    sym_e              stuff_sym;
    sym_e              sync_sym;

    assign op_raw    = (opmode_i == OPM_RAW);
    assign raw_emit  = s_q.raw | s_q.err | op_raw;
    assign sh_shift  = s_q.sh >> s_q.cnt;
    assign cur_bit   = sh_shift[0];
    assign stuff_due = (s_q.ones == OW'(STUFF_LEN));

    usbtx_sym_enc u_data_enc (
        .dat_i (cur_bit),
        .raw_i (raw_emit),
        .prev_i(s_q.line),
        .sym_o (data_sym)
    );

    usbtx_sym_enc u_stuff_enc (
        .dat_i (1'b0),
        .raw_i (1'b0),
        .prev_i(s_q.line),
        .sym_o (stuff_sym)
    );

    usbtx_sync_gen #(
        .SYNC_LEN(SYNC_LEN),
        .IW      (CW)
    ) u_sync (
        .idx_i(s_q.cnt),
        .sym_o(sync_sym)
    );

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                s_d.line = SYM_J;
                s_d.cnt  = '0;
                s_d.ones = '0;
                s_d.err  = 1'b0;
                s_d.raw  = 1'b0;
                if (tx_valid_i) begin
                    if (op_raw) begin
                        take     = 1'b1;
                        s_d.sh   = tx_data_i;
                        s_d.raw  = 1'b1;
                        s_d.st   = ST_DATA;
                    end else begin
                        s_d.st   = ST_SYNC;
                    end
                end
            end
            ST_SYNC: begin
                s_d.line = sync_sym;
                s_d.err  = s_q.err | op_raw;
                if (s_q.cnt == CW'(SYNC_LEN - 1)) begin
                    s_d.cnt = '0;
                    if (tx_valid_i) begin
                        take   = 1'b1;
                        s_d.sh = tx_data_i;
                        s_d.st = ST_DATA;
                    end else begin
                        s_d.st = ST_EOP;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_DATA: begin
                s_d.err = s_q.err | (op_raw & ~s_q.raw);
                if (!raw_emit && stuff_due) begin
                    s_d.line = stuff_sym;
                    s_d.ones = '0;
                end else begin
                    s_d.line = data_sym;
                    s_d.ones = (raw_emit || !cur_bit) ? '0 : s_q.ones + 1'b1;
                    if (s_q.cnt == CW'(BYTE_W - 1)) begin
                        s_d.cnt = '0;
                        if (tx_valid_i) begin
                            take   = 1'b1;
                            s_d.sh = tx_data_i;
                        end else begin
                            s_d.st = s_q.raw ? ST_IDLE : ST_EOP;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            ST_EOP: begin
                if (s_q.cnt == '0 && stuff_due) begin
                    s_d.line = stuff_sym;
                    s_d.ones = '0;
                end else if (s_q.cnt < CW'(EOP_SE0)) begin
                    s_d.line = SYM_SE0;
                    s_d.cnt  = s_q.cnt + 1'b1;
                end else begin
                    s_d.line = SYM_J;
                    s_d.cnt  = '0;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: '0, sh: '0, ones: '0,
                     raw: 1'b0, err: 1'b0, line: SYM_J};
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_ready_o = take;
    assign line_o     = s_q.line;
endmodule

// File: rtl/usbtx_chk.sv
module usbtx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid_i,
    input logic       tx_ready_o,
    input logic [1:0] line_o
);
    localparam logic [1:0] L_SE0 = 2'b00;
    localparam logic [1:0] L_J   = 2'b01;

    a_r6_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> tx_valid_i);

    a_r6_ready_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |=> !tx_ready_o);

    a_r10_se0_max_two: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o == L_SE0 && $past(line_o) == L_SE0) |=> (line_o != L_SE0));

    a_r5_eop_then_j: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o == L_SE0 && $past(line_o) == L_SE0) |=> (line_o == L_J));

    a_r2_start_drives_j: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_valid_i) && line_o == L_J) |=> (line_o == L_J));
endmodule

bind usbtx_serializer usbtx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o),
    .line_o    (line_o)
);

// File: tb/tb_usbtx_serializer.sv
module tb_usbtx_serializer;
    localparam int CLK_P = 10;
    localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_valid_i = 1'b0;
    logic [7:0] tx_data_i = 8'h00;
    logic [1:0] opmode_i = 2'b00;
    logic       tx_ready_o;
    logic [1:0] line_o;

    int         vectors = 0;
    int         miscompares = 0;
    int         cycles = 0;
    int         se0_run = 0;
    bit         mon_on = 1'b0;
    string      cur_tag = "R1";
    logic [1:0] exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    usbtx_serializer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_valid_i(tx_valid_i),
        .tx_data_i (tx_data_i),
        .opmode_i  (opmode_i),
        .tx_ready_o(tx_ready_o),
        .line_o    (line_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [1:0] tog(input logic [1:0] s);
        return (s == K) ? J : K;
    endfunction

    // Reference stream: leading J, framing, stuffing, NRZI or raw mapping.
    function automatic void build(input logic [7:0] b[$], input bit raw_start,
                                  input int raw_from);
        logic [1:0] level = K;
        int ones = 0;
        exp_q.push_back(J);
        if (!raw_start) begin
            for (int s = 0; s < 8; s++) exp_q.push_back((s == 7 || s % 2 == 0) ? K : J);
        end
        for (int i = 0; i < b.size(); i++) begin
            bit raw = raw_start || (raw_from >= 0 && i >= raw_from);
            for (int j = 0; j < 8; j++) begin
                bit bt = b[i][j];
                if (raw) begin
                    exp_q.push_back(bt ? J : K);
                    ones = 0;
                end else begin
                    if (ones == 6) begin
                        level = tog(level);
                        exp_q.push_back(level);
                        ones = 0;
                    end
                    if (bt) ones++;
                    else begin
                        level = tog(level);
                        ones = 0;
                    end
                    exp_q.push_back(level);
                end
            end
        end
        if (!raw_start) begin
            if (ones == 6) exp_q.push_back(tog(level));
            exp_q.push_back(SE0);
            exp_q.push_back(SE0);
            exp_q.push_back(J);
        end
    endfunction

    // Per-clock comparison of the line against the model (idle J when empty).
    always @(posedge clk) begin
        if (mon_on) begin
            logic [1:0] e;
            #(CLK_P/4);
            e = (exp_q.size() > 0) ? exp_q.pop_front() : J;
            check(line_o == e, cur_tag, line_o, e);
            se0_run = (line_o == SE0) ? se0_run + 1 : 0;
            if (se0_run > 0) check(se0_run <= 2, "R10", se0_run, 2);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic run_pkt(input logic [7:0] b[$], input logic [1:0] mode,
                           input bit raw_start, input int raw_from, input string tag);
        int i = 0;
        int rdy_cnt = 0;
        bit r;
        @(negedge clk);
        cur_tag = tag;
        build(b, raw_start, raw_from);
        opmode_i   = raw_start ? 2'b10 : mode;
        tx_valid_i = 1'b1;
        tx_data_i  = b[0];
        forever begin
            #1 r = tx_ready_o;
            if (r) rdy_cnt++;
            @(negedge clk);
            if (r) begin
                if (raw_from >= 0 && i == raw_from) opmode_i = 2'b10;
                i++;
                if (i == b.size()) begin
                    tx_valid_i = 1'b0;
                    tx_data_i  = 8'h00;
                    break;
                end
                tx_data_i = b[i];
            end
        end
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        opmode_i = 2'b00;
        // R6: one ready pulse per byte taken
        check(rdy_cnt == b.size(), "R6", rdy_cnt, b.size());
        check(tx_ready_o == 1'b0, "R1", tx_ready_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(line_o == J, "R1", line_o, J);
        check(tx_ready_o == 1'b0, "R1", tx_ready_o, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (3) @(negedge clk);

        run_pkt('{8'hA5, 8'h3C}, 2'b00, 1'b0, -1, "R2 R3 R5");
        run_pkt('{8'hFF, 8'hFF, 8'h81}, 2'b00, 1'b0, -1, "R4");
        run_pkt('{8'hFC}, 2'b00, 1'b0, -1, "R4 R5");
        run_pkt('{8'hA5, 8'h0F}, 2'b11, 1'b0, -1, "R8");
        run_pkt('{8'hFF, 8'h00, 8'hC3}, 2'b00, 1'b1, -1, "R7");
        run_pkt('{8'h12, 8'hFF, 8'h34}, 2'b00, 1'b0, 1, "R9");
        run_pkt('{8'h7E}, 2'b00, 1'b0, 0, "R9 R5");
        repeat (4) @(negedge clk);
        check(line_o == J, "R1", line_o, J);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule